// File: doc/BRIEF.md
# LPC Host Controller Register Block

This block holds the software-visible configuration and interrupt state of an LPC host controller. A processor reaches it through single-word accesses on an on-chip bus. Each access carries an offset, a byte count, a direction and a 32-bit data word. Bit 31 of the data word is the most significant bit of the register. Only whole-word accesses reach a register. An access with any other byte count is refused.

The LPC cycle engine and the serial-IRQ deserializer sit outside this block. They report their events to it as one-cycle pulses. Each event sets a sticky bit in the interrupt status register, and software clears that bit by writing a one to it. A single interrupt line is raised while any status bit that is enabled in the mask register is set. The cycle engine can also capture a failing bus address into a register that software can only read.

Top module: `lpc_hc_regblk`

## Requirements
- R1: After reset, the firmware read-size register (offset 0x28) reads 0x02000000, which is the 4-byte code. The segment register (0x24), serial-IRQ control (0x30), mask (0x34), status (0x38) and error address (0x40) all read zero, and `irq_out` is low.
- R2: A read request (`bus_valid` high, `bus_write` low) is answered on the next clock edge. At that edge `rd_valid` rises for one cycle and `rd_data` carries the word.
- R3: The registers at offsets 0x24, 0x28, 0x30 and 0x34 read back the last full word written to them. The size codes 0x00000000, 0x01000000, 0x02000000, 0x04000000 and 0x07000000 mean 1, 2, 4, 16 and 128 bytes. In serial-IRQ control, bit 31 is enable and bit 30 is quiet mode. Bits 25:24 of that register select a start frame of 4, 6 or 8 clocks (codes 0, 1, 2).
- R4: Status bits are sticky. A write to offset 0x38 clears each bit that is written as one and leaves every other bit unchanged.
- R5: An event pulse sets its status bit on the next edge. Serial IRQ line i (0..16) sets bit 31-i. LPC reset sets bit 10. `evt_sync[k]` sets bit k, for k from 0 to 7.
- R6: If an event and a clearing write hit the same status bit in the same cycle, the bit stays set.
- R7: `irq_out` equals the OR of (status AND mask) from the previous cycle. The mask has the same bit layout as the status register.
- R8: The error address register (0x40) loads `err_addr` when `err_capture` is high. Bus writes to 0x40 leave it unchanged.
- R9: A read from an offset with no register returns 0xFFFFFFFF. A write to such an offset changes no register.
- R10: An access whose `bus_size` is not 4 writes nothing, and a read of that kind returns 0xFFFFFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Access request, one cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_size | input | 3 | Byte count of the access |
| bus_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |
| evt_serirq | input | 17 | Serial IRQ event pulses, index = IRQ number |
| evt_lreset | input | 1 | LPC reset event pulse |
| evt_sync | input | 8 | Sync error and bus-master request pulses |
| err_capture | input | 1 | Load the error address |
| err_addr | input | 32 | Failing LPC address |
| irq_out | output | 1 | Combined interrupt |

## Verification
Read data appears one edge after the request, so each read task drives on a falling edge and samples at the next falling edge. An event or a clearing write changes status one edge after it is applied. A read issued on the following falling edge sees the new value. `irq_out` adds one more register, so after a mask or status change the bench waits one extra cycle before it samples the line. For the same-cycle case, the event and the clearing write are driven together in a single cycle, and the status is read back afterwards.

// File: rtl/lpc_hc_pkg.sv
package lpc_hc_pkg;
  localparam int DW = 32;
  localparam int N_SERIRQ = 17;
  localparam int N_SYNC = 8;
  localparam int LRESET_BIT = 10;
  localparam logic [DW-1:0] SIZE_RST = 32'h0200_0000;

  localparam logic [7:0] OFS_SEG  = 8'h24;
  localparam logic [7:0] OFS_SIZE = 8'h28;
  localparam logic [7:0] OFS_SER  = 8'h30;
  localparam logic [7:0] OFS_MASK = 8'h34;
  localparam logic [7:0] OFS_STAT = 8'h38;
  localparam logic [7:0] OFS_ERR  = 8'h40;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_SEG, SEL_SIZE, SEL_SER, SEL_MASK, SEL_STAT, SEL_ERR
  } reg_sel_e;
endpackage

// File: rtl/lpc_hc_decode.sv
module lpc_hc_decode #(
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0]      addr,
  input  logic [2:0]             size,
  output lpc_hc_pkg::reg_sel_e   sel,
  output logic                   size_ok
);
  import lpc_hc_pkg::*;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [7:0] ofs);
    return a == ADDR_W'(ofs);
  endfunction

  assign size_ok = (size == 3'd4);

  always_comb begin
    sel = SEL_NONE;
    if      (hit(addr, OFS_SEG))  sel = SEL_SEG;
    else if (hit(addr, OFS_SIZE)) sel = SEL_SIZE;
    else if (hit(addr, OFS_SER))  sel = SEL_SER;
    else if (hit(addr, OFS_MASK)) sel = SEL_MASK;
    else if (hit(addr, OFS_STAT)) sel = SEL_STAT;
    else if (hit(addr, OFS_ERR))  sel = SEL_ERR;
  end
endmodule

// File: rtl/lpc_hc_cfg_regs.sv
module lpc_hc_cfg_regs (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  lpc_hc_pkg::reg_sel_e     sel,
  input  logic [31:0]              wdata,
  input  logic                     err_capture,
  input  logic [31:0]              err_addr,
  output logic [31:0]              seg_q,
  output logic [31:0]              size_q,
  output logic [31:0]              ser_q,
  output logic [31:0]              mask_q,
  output logic [31:0]              err_q
);
  import lpc_hc_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      seg_q  <= '0;
      size_q <= SIZE_RST;
      ser_q  <= '0;
      mask_q <= '0;
    end else if (wr_en) begin
      case (sel)
        SEL_SEG:  seg_q  <= wdata;
        SEL_SIZE: size_q <= wdata;
        SEL_SER:  ser_q  <= wdata;
        SEL_MASK: mask_q <= wdata;
        default: ;
      endcase
    end
  end

  // Error address: loaded by hardware only
  always_ff @(posedge clk) begin
    if (rst)              err_q <= '0;
    else if (err_capture) err_q <= err_addr;
  end
endmodule

// File: rtl/lpc_hc_irq_stat.sv
module lpc_hc_irq_stat (
  input  logic                              clk,
  input  logic                              rst,
  input  logic [lpc_hc_pkg::N_SERIRQ-1:0]   evt_serirq,
  input  logic                              evt_lreset,
  input  logic [lpc_hc_pkg::N_SYNC-1:0]     evt_sync,
  input  logic                              clr_en,
  input  logic [31:0]                       clr_bits,
  input  logic [31:0]                       mask,
  output logic [31:0]                       evt_vec,
  output logic [31:0]                       stat_q,
  output logic                              irq_q
);
  import lpc_hc_pkg::*;

  // Serial IRQ n lands on bit DW-1-n; sync bits land at their own index
  for (genvar b = 0; b < DW; b++) begin : g_map
    if (b >= DW - N_SERIRQ) begin : g_ser
      assign evt_vec[b] = evt_serirq[DW-1-b];
    end else if (b == LRESET_BIT) begin : g_lrst
      assign evt_vec[b] = evt_lreset;
    end else if (b < N_SYNC) begin : g_sync
      assign evt_vec[b] = evt_sync[b];
    end else begin : g_rsvd
      assign evt_vec[b] = 1'b0;
    end
  end

  logic [31:0] clr_mask;
  assign clr_mask = clr_en ? clr_bits : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      stat_q <= (stat_q & ~clr_mask) | evt_vec;   // event wins
      irq_q  <= |(stat_q & mask);
    end
  end
endmodule

// File: rtl/lpc_hc_regblk.sv
module lpc_hc_regblk #(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [2:0]        bus_size,
  input  logic [31:0]       bus_wdata,
  output logic              rd_valid,
  output logic [31:0]       rd_data,
  input  logic [16:0]       evt_serirq,
  input  logic              evt_lreset,
  input  logic [7:0]        evt_sync,
  input  logic              err_capture,
  input  logic [31:0]       err_addr,
  output logic              irq_out
);
  import lpc_hc_pkg::*;

  reg_sel_e    sel;
  logic        size_ok;
  logic        wr_en;
  logic        clr_en;
  logic [31:0] seg_q, size_q, ser_q, mask_q, err_q, stat_q, evt_vec;

  lpc_hc_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr(bus_addr), .size(bus_size), .sel(sel), .size_ok(size_ok)
  );

  assign wr_en  = bus_valid & bus_write & size_ok;
  assign clr_en = wr_en & (sel == SEL_STAT);

  lpc_hc_cfg_regs u_cfg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .sel(sel), .wdata(bus_wdata),
    .err_capture(err_capture), .err_addr(err_addr),
    .seg_q(seg_q), .size_q(size_q), .ser_q(ser_q), .mask_q(mask_q), .err_q(err_q)
  );

  lpc_hc_irq_stat u_irq (
    .clk(clk), .rst(rst), .evt_serirq(evt_serirq), .evt_lreset(evt_lreset),
    .evt_sync(evt_sync), .clr_en(clr_en), .clr_bits(bus_wdata), .mask(mask_q),
    .evt_vec(evt_vec), .stat_q(stat_q), .irq_q(irq_out)
  );

  logic [31:0] rd_mux;
  always_comb begin
    rd_mux = '1;
    if (size_ok) begin
      case (sel)
        SEL_SEG:  rd_mux = seg_q;
        SEL_SIZE: rd_mux = size_q;
        SEL_SER:  rd_mux = ser_q;
        SEL_MASK: rd_mux = mask_q;
        SEL_STAT: rd_mux = stat_q;
        SEL_ERR:  rd_mux = err_q;
        default:  rd_mux = '1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= bus_valid & ~bus_write;
      if (bus_valid & ~bus_write) rd_data <= rd_mux;
    end
  end
endmodule

// File: rtl/lpc_hc_regblk_chk.sv
module lpc_hc_regblk_chk (
  input logic        clk,
  input logic        rst,
  input logic        bus_valid,
  input logic        bus_write,
  input logic        rd_valid,
  input logic        clr_en,
  input logic [31:0] evt_vec,
  input logic [31:0] stat_q,
  input logic [31:0] mask_q,
  input logic        irq_out,
  input logic        err_capture,
  input logic [31:0] err_q
);
  a_r2_read_answer: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && !bus_write) |=> rd_valid);
  a_r4_sticky: assert property (@(posedge clk) disable iff (rst)
    !clr_en |=> ((stat_q & $past(stat_q)) == $past(stat_q)));
  a_r5_event_sets: assert property (@(posedge clk) disable iff (rst)
    (|evt_vec) |=> ((stat_q & $past(evt_vec)) == $past(evt_vec)));
  a_r7_irq_high: assert property (@(posedge clk) disable iff (rst)
    (|(stat_q & mask_q)) |=> irq_out);
  a_r7_irq_low: assert property (@(posedge clk) disable iff (rst)
    !(|(stat_q & mask_q)) |=> !irq_out);
  a_r8_err_hold: assert property (@(posedge clk) disable iff (rst)
    !err_capture |=> $stable(err_q));
endmodule

bind lpc_hc_regblk lpc_hc_regblk_chk u_chk (
  .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
  .rd_valid(rd_valid), .clr_en(clr_en), .evt_vec(evt_vec), .stat_q(stat_q),
  .mask_q(mask_q), .irq_out(irq_out), .err_capture(err_capture), .err_q(err_q)
);

// File: tb/lpc_hc_regblk_tb.sv
module lpc_hc_regblk_tb;
  localparam int ADDR_W = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_valid = 1'b0, bus_write = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [2:0] bus_size = 3'd4;
  logic [31:0] bus_wdata = '0;
  logic rd_valid;
  logic [31:0] rd_data;
  logic [16:0] evt_serirq = '0;
  logic evt_lreset = 1'b0;
  logic [7:0] evt_sync = '0;
  logic err_capture = 1'b0;
  logic [31:0] err_addr = '0;
  logic irq_out;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  lpc_hc_regblk #(.ADDR_W(ADDR_W)) u_dut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic [2:0] sz = 3'd4);
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d; bus_size = sz;
    @(negedge clk);
    bus_valid = 0; bus_write = 0; bus_size = 3'd4;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d, input logic [2:0] sz = 3'd4);
    @(negedge clk);
    bus_valid = 1; bus_write = 0; bus_addr = a; bus_size = sz;
    @(negedge clk);
    bus_valid = 0; bus_size = 3'd4;
    check("R2 rd_valid", {31'd0, rd_valid}, 32'd1);
    d = rd_data;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check("R1 irq", {31'd0, irq_out}, 0);
    rd(12'h28, v); check("R1 size", v, 32'h0200_0000);
    rd(12'h24, v); check("R1 seg", v, 0);
    rd(12'h38, v); check("R1 stat", v, 0);
    rd(12'h40, v); check("R1 err", v, 0);
  endtask

  task automatic t_rw();
    logic [31:0] v;
    wr(12'h24, 32'hA5A5_1234); rd(12'h24, v); check("R3 seg", v, 32'hA5A5_1234);
    wr(12'h28, 32'h0700_0000); rd(12'h28, v); check("R3 size", v, 32'h0700_0000);
    wr(12'h30, 32'hC100_0000); rd(12'h30, v); check("R3 serctl", v, 32'hC100_0000);
    wr(12'h34, 32'h0000_0000); rd(12'h34, v); check("R3 mask", v, 0);
  endtask

  task automatic pulse(input logic [16:0] s, input logic l, input logic [7:0] y);
    @(negedge clk);
    evt_serirq = s; evt_lreset = l; evt_sync = y;
    @(negedge clk);
    evt_serirq = '0; evt_lreset = 0; evt_sync = '0;
  endtask

  task automatic t_events();
    logic [31:0] v;
    pulse(17'h00001, 0, 0); rd(12'h38, v); check("R5 serirq0", v, 32'h8000_0000);
    pulse(17'h10000, 0, 0); rd(12'h38, v); check("R5 serirq16", v, 32'h8000_8000);
    pulse(0, 1, 0);         rd(12'h38, v); check("R5 lreset", v, 32'h8000_8400);
    pulse(0, 0, 8'h81);     rd(12'h38, v); check("R5 sync", v, 32'h8000_8481);
    check("R7 masked off", {31'd0, irq_out}, 0);
  endtask

  task automatic t_w1c();
    logic [31:0] v;
    wr(12'h38, 32'h8000_0001); rd(12'h38, v); check("R4 w1c", v, 32'h0000_8480);
  endtask

  task automatic t_irq();
    wr(12'h34, 32'h0000_0400);
    @(negedge clk); check("R7 irq on", {31'd0, irq_out}, 1);
    wr(12'h38, 32'h0000_0400);
    @(negedge clk); check("R7 irq off", {31'd0, irq_out}, 0);
  endtask

  task automatic t_race();
    logic [31:0] v;
    @(negedge clk);
    evt_sync = 8'h10;
    bus_valid = 1; bus_write = 1; bus_addr = 12'h38; bus_wdata = 32'h0000_0010;
    @(negedge clk);
    evt_sync = 0; bus_valid = 0; bus_write = 0;
    rd(12'h38, v); check("R6 event wins", v & 32'h10, 32'h10);
  endtask

  task automatic t_err();
    logic [31:0] v;
    @(negedge clk); err_capture = 1; err_addr = 32'h0000_1234;
    @(negedge clk); err_capture = 0; err_addr = 0;
    rd(12'h40, v); check("R8 capture", v, 32'h0000_1234);
    wr(12'h40, 32'hFFFF_0000); rd(12'h40, v); check("R8 read-only", v, 32'h0000_1234);
  endtask

  task automatic t_unmap();
    logic [31:0] v;
    rd(12'h2C, v); check("R9 unmapped read", v, 32'hFFFF_FFFF);
    wr(12'h2C, 32'h0); wr(12'h000, 32'h0);
    rd(12'h24, v); check("R9 unmapped write", v, 32'hA5A5_1234);
  endtask

  task automatic t_size();
    logic [31:0] v;
    wr(12'h24, 32'h0, 3'd2); rd(12'h24, v); check("R10 short write", v, 32'hA5A5_1234);
    rd(12'h24, v, 3'd1); check("R10 short read", v, 32'hFFFF_FFFF);
  endtask

  initial begin : wdog
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_rw();
    t_events();
    t_w1c();
    t_irq();
    t_race();
    t_err();
    t_unmap();
    t_size();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule